// File: doc/BRIEF.md
# Two-Wire Register-File Target with Pointer Auto-Increment

This block is the serial control port of a charger-detection controller. A host on a two-wire serial bus (I2C) reads and writes a map of five byte-wide registers. Two are read-only: an identity byte and a status byte that is assembled from live inputs. Three are control registers whose contents leave the block as parallel outputs. The block runs entirely on the system clock. It oversamples both bus lines through synchronizers and a glitch filter, detects START, repeated START and STOP, and answers only its own 7-bit address.

After a write address, the first byte loads an internal register pointer. Every further data byte goes to the pointed register, and the pointer then steps by one. Reads begin at the stored pointer and step the same way. A host can therefore aim the pointer with a short write that it ends with STOP, and then read from that point later. SDA is driven as an open-drain pull-down enable.

Two side channels serve the neighbouring detection logic. A one-cycle strobe marks each time the status byte is fetched for transmission. A self-clear input drops the manual-detect request bit once the detection logic has taken it.

Top module: `i2c_regfile_target`

## Requirements
- R1: The target acknowledges (pulls SDA low on the ninth clock) address bytes 0x58 (write) and 0x59 (read), i.e. 7-bit address 0x2C; any other address byte gets no acknowledge, and SDA is not driven until the next START.
- R2: The first byte after a write address loads the pointer; a STOP right after it changes no register.
- R3: Each later data byte of a write is stored at the pointer, and the pointer then increments, so a burst fills consecutive registers; control registers hold their value when no write and no self-clear occurs.
- R4: A read returns the byte at the stored pointer and increments the pointer per byte; after the host answers a byte with NACK the target releases SDA.
- R5: Register 0x00 always reads 0x21 (upper nibble 0x2, lower nibble 0x1), and writes to it are ignored.
- R6: Register 0x01 resets to 0x09, all eight bits are read/write, and its value appears on `ctrl1_q` (bit 7 interrupt polarity, bit 6 interrupt enable, bit 5 switch close, bit 4 charge pump, bit 3 low power, bit 2 long check, bit 1 manual detect, bit 0 detect enable).
- R7: Register 0x02 reads {det_type[2:0], vb_comp, 0, dcd_timeout, det_running, 0} (type in bits 7:5, comparator in bit 4, timeout in bit 2, running in bit 1), and writes to it are ignored.
- R8: Register 0x03 resets to 0x80; bits 6:5 are read-only zero, and the other bits are read/write and appear on `ctrl2_q`.
- R9: Register 0x04 resets to 0x0B; bits 7:5 are read-only zero, and bits 4:0 are read/write and appear on `ctrl3_q`.
- R10: Pointer values above 0x04 read as 0x00, and writes to them change nothing.
- R11: `manual_clr` high clears `ctrl1_q[1]` at the next clock, and it takes priority over a host write to register 0x01 in the same cycle.
- R12: `irq_rd` pulses high for exactly one cycle each time register 0x02 is fetched for transmission to the host.
- R13: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low |
| det_type | input | 3 | Detected charger type code |
| vb_comp | input | 1 | Bus-voltage comparator state |
| dcd_timeout | input | 1 | Data-contact wait timed out |
| det_running | input | 1 | Detection sequence running |
| manual_clr | input | 1 | Clears the manual-detect bit |
| ctrl1_q | output | 8 | Control register 0x01 |
| ctrl2_q | output | 8 | Control register 0x03 |
| ctrl3_q | output | 8 | Control register 0x04 |
| irq_rd | output | 1 | Status register fetched for a read |

## Verification
A host write to register 0x01 and the self-clear of its manual-detect bit can land in the same clock cycle. The bench provokes this by holding `manual_clr` high for the whole write transaction, so the commit cycle is covered whatever the filter latency. It then reads the register back over the bus and expects every written bit except bit 1. Burst sweeps over all registers with several data patterns, and a sweep of status input codes, compare each read byte with a model built from the masks and reset values.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } tgt_state_e;

   localparam int          REG_COUNT  = 5;
   localparam logic [7:0]  ADR_ID     = 8'h00;
   localparam logic [7:0]  ADR_CTRL1  = 8'h01;
   localparam logic [7:0]  ADR_STATUS = 8'h02;
   localparam logic [7:0]  ADR_CTRL2  = 8'h03;
   localparam logic [7:0]  ADR_CTRL3  = 8'h04;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_out
);
   localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
   end

   generate
      if (FILT_LEN <= 1) begin : g_nofilt
         assign line_out = sync_q[SYNC_STAGES-1];
      end else begin : g_filt
         logic [CW-1:0] cnt_q;
         logic          out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               out_q <= 1'b1;
            end else if (sync_q[SYNC_STAGES-1] == out_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
               out_q <= sync_q[SYNC_STAGES-1];
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
         assign line_out = out_q;
      end
   endgenerate
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
   import i2creg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h2C
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_f,
   input  logic       sda_f,
   input  logic [7:0] rd_data,
   output logic [7:0] rd_addr,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data,
   output logic       ld_pulse,
   output logic [7:0] ld_addr,
   output logic       sda_oe,
   output logic       bus_evt,
   output logic       idle
);
   tgt_state_e state;
   logic       scl_d, sda_d;
   logic [3:0] bitcnt;
   logic [7:0] shreg, ptr;
   logic       addr_ph, first, is_rd, nack;
   logic       scl_rise, scl_fall, start_c, stop_c, do_load;

   assign scl_rise = scl_f & ~scl_d;
   assign scl_fall = ~scl_f & scl_d;
   assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;
   assign bus_evt  = start_c | stop_c;
   assign rd_addr  = ptr;
   assign idle     = (state == ST_IDLE);

   always_comb begin
      do_load = scl_fall && ((state == ST_ACK && is_rd) || (state == ST_MACK && !nack));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; scl_d <= 1'b1; sda_d <= 1'b1;
         bitcnt <= '0; shreg <= '0; ptr <= '0;
         addr_ph <= 1'b0; first <= 1'b0; is_rd <= 1'b0; nack <= 1'b0;
         wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
         ld_pulse <= 1'b0; ld_addr <= '0; sda_oe <= 1'b0;
      end else begin
         scl_d    <= scl_f;
         sda_d    <= sda_f;
         wr_en    <= 1'b0;
         ld_pulse <= 1'b0;
         if (start_c) begin
            state <= ST_RX; bitcnt <= '0; addr_ph <= 1'b1; sda_oe <= 1'b0;
         end else if (stop_c) begin
            state <= ST_IDLE; sda_oe <= 1'b0;
         end else if (do_load) begin
            shreg    <= rd_data;
            sda_oe   <= ~rd_data[7];
            ld_pulse <= 1'b1;
            ld_addr  <= ptr;
            ptr      <= ptr + 8'd1;
            bitcnt   <= '0;
            state    <= ST_TX;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_f};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     if (addr_ph) begin
                        addr_ph <= 1'b0;
                        if (shreg[7:1] == DEV_ADDR) begin
                           sda_oe <= 1'b1; state <= ST_ACK;
                           is_rd  <= shreg[0]; first <= 1'b1;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        sda_oe <= 1'b1; state <= ST_ACK;
                        if (first) begin
                           ptr <= shreg; first <= 1'b0;
                        end else begin
                           wr_en <= 1'b1; wr_addr <= ptr; wr_data <= shreg;
                           ptr <= ptr + 8'd1;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0; state <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == 4'd7) begin
                        sda_oe <= 1'b0; state <= ST_MACK;
                     end else begin
                        bitcnt <= bitcnt + 4'd1;
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) nack <= sda_f;
                  else if (scl_fall) state <= ST_IDLE;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank
   import i2creg_pkg::*;
#(
   parameter logic [7:0] ID_VALUE   = 8'h21,
   parameter logic [7:0] RST_CTRL1  = 8'h09,
   parameter logic [7:0] RST_CTRL2  = 8'h80,
   parameter logic [7:0] RST_CTRL3  = 8'h0B,
   parameter logic [7:0] MASK_CTRL2 = 8'h9F,
   parameter logic [7:0] MASK_CTRL3 = 8'h1F,
   parameter int         CLR_BIT    = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [7:0] rd_addr,
   output logic [7:0] rd_data,
   input  logic [7:0] status_byte,
   input  logic       manual_clr,
   output logic [7:0] ctrl1_q,
   output logic [7:0] ctrl2_q,
   output logic [7:0] ctrl3_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl1_q <= RST_CTRL1;
         ctrl2_q <= RST_CTRL2 & MASK_CTRL2;
         ctrl3_q <= RST_CTRL3 & MASK_CTRL3;
      end else begin
         if (wr_en && wr_addr == ADR_CTRL1) ctrl1_q <= wr_data;
         if (wr_en && wr_addr == ADR_CTRL2) ctrl2_q <= wr_data & MASK_CTRL2;
         if (wr_en && wr_addr == ADR_CTRL3) ctrl3_q <= wr_data & MASK_CTRL3;
         if (manual_clr) ctrl1_q[CLR_BIT] <= 1'b0;
      end
   end

   always_comb begin
      unique case (rd_addr)
         ADR_ID:     rd_data = ID_VALUE;
         ADR_CTRL1:  rd_data = ctrl1_q;
         ADR_STATUS: rd_data = status_byte;
         ADR_CTRL2:  rd_data = ctrl2_q;
         ADR_CTRL3:  rd_data = ctrl3_q;
         default:    rd_data = 8'h00;
      endcase
   end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
   import i2creg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2C,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       sda_oe,
   input  logic [2:0] det_type,
   input  logic       vb_comp,
   input  logic       dcd_timeout,
   input  logic       det_running,
   input  logic       manual_clr,
   output logic [7:0] ctrl1_q,
   output logic [7:0] ctrl2_q,
   output logic [7:0] ctrl3_q,
   output logic       irq_rd
);
   localparam int LINES = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
   endgenerate

   logic [LINES-1:0] raw_l, filt_l;
   assign raw_l = {sda_in, scl_in};

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_filt (
            .clk(clk), .rst_n(rst_n), .line_in(raw_l[g]), .line_out(filt_l[g])
         );
      end
   endgenerate

   logic       scl_f, sda_f;
   logic [7:0] rd_data, rd_addr, wr_addr, wr_data, ld_addr, status_byte;
   logic       wr_en, ld_pulse, bus_evt, fsm_idle;

   assign scl_f       = filt_l[0];
   assign sda_f       = filt_l[1];
   assign status_byte = {det_type, vb_comp, 1'b0, dcd_timeout, det_running, 1'b0};
   assign irq_rd      = ld_pulse && (ld_addr == ADR_STATUS);

   i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) i_fsm (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .rd_data(rd_data), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ld_pulse(ld_pulse), .ld_addr(ld_addr),
      .sda_oe(sda_oe), .bus_evt(bus_evt), .idle(fsm_idle)
   );

   i2c_regbank i_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .status_byte(status_byte),
      .manual_clr(manual_clr),
      .ctrl1_q(ctrl1_q), .ctrl2_q(ctrl2_q), .ctrl3_q(ctrl3_q)
   );
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sda_oe,
   input logic       scl_f,
   input logic       bus_evt,
   input logic       fsm_idle,
   input logic       wr_en,
   input logic       manual_clr,
   input logic [7:0] ctrl1_q,
   input logic [7:0] ctrl2_q,
   input logic [7:0] ctrl3_q,
   input logic       irq_rd
);
   assert_sda_moves_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(bus_evt)) |-> !scl_f);

   assert_selfclr_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      manual_clr |=> !ctrl1_q[1]);

   assert_strobe_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rd |=> !irq_rd);

   assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !manual_clr) |=> ($stable(ctrl1_q) && $stable(ctrl2_q) && $stable(ctrl3_q)));

   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fsm_idle |-> !sda_oe);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk i_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_f(scl_f), .bus_evt(bus_evt),
   .fsm_idle(fsm_idle), .wr_en(wr_en), .manual_clr(manual_clr),
   .ctrl1_q(ctrl1_q), .ctrl2_q(ctrl2_q), .ctrl3_q(ctrl3_q), .irq_rd(irq_rd)
);

// File: tb/test_i2c_regfile_target.sv
`timescale 1ns/1ps
module test_i2c_regfile_target;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic [2:0] det_type = '0;
   logic vb_comp = 1'b0, dcd_timeout = 1'b0, det_running = 1'b0, manual_clr = 1'b0;
   logic sda_oe, irq_rd;
   logic [7:0] ctrl1_q, ctrl2_q, ctrl3_q;
   logic sda_line;

   int checks = 0, fails = 0, irq_cnt = 0, r13_bad = 0;
   logic prev_oe = 1'b0;
   logic [7:0] m1 = 8'h09, m2 = 8'h80, m3 = 8'h0B;

   always #2.5 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2c_regfile_target i_i2c_regfile_target (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
      .det_type(det_type), .vb_comp(vb_comp), .dcd_timeout(dcd_timeout),
      .det_running(det_running), .manual_clr(manual_clr),
      .ctrl1_q(ctrl1_q), .ctrl2_q(ctrl2_q), .ctrl3_q(ctrl3_q), .irq_rd(irq_rd)
   );

   always @(posedge clk) begin
      if (irq_rd) irq_cnt <= irq_cnt + 1;
      if (sda_oe != prev_oe && scl_m) r13_bad <= r13_bad + 1;
      prev_oe <= sda_oe;
   end

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic logic [7:0] stat_exp();
      return {det_type, vb_comp, 1'b0, dcd_timeout, det_running, 1'b0};
   endfunction

   function automatic logic [7:0] model_rd(input int a);
      case (a)
         0: return 8'h21;
         1: return m1;
         2: return stat_exp();
         3: return m2;
         4: return m3;
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_wr(input int a, input logic [7:0] v);
      case (a)
         1: m1 = v;
         3: m2 = v & 8'h9F;
         4: m3 = v & 8'h1F;
         default: ;
      endcase
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line;
      tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic wbyte(input logic [7:0] v, output logic ack_n);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(ack_n);
   endtask

   task automatic rbyte(input logic send_nack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(send_nack);
   endtask

   task automatic set_ptr(input logic [7:0] p, input logic do_stop);
      logic a;
      bus_start();
      wbyte(8'h58, a); check("R1 write address ack", {7'd0, a}, 8'h00);
      wbyte(p, a);     check("R2 pointer byte ack", {7'd0, a}, 8'h00);
      if (do_stop) bus_stop();
   endtask

   task automatic burst_write(input logic [7:0] p, input logic [7:0] seed, input int n);
      logic a;
      set_ptr(p, 1'b0);
      for (int k = 0; k < n; k++) begin
         logic [7:0] v;
         v = seed ^ 8'(k * 8'h11);
         wbyte(v, a);
         model_wr(int'(p) + k, v);
      end
      bus_stop();
   endtask

   task automatic burst_read(input logic [7:0] p, input int n, input string tag);
      logic a;
      logic [7:0] v;
      set_ptr(p, 1'b0);
      bus_start();
      wbyte(8'h59, a); check("R1 read address ack", {7'd0, a}, 8'h00);
      for (int k = 0; k < n; k++) begin
         rbyte(k == n - 1, v);
         check(tag, v, model_rd(int'(p) + k));
      end
      bus_stop();
   endtask

   task automatic check_ports();
      check("R6 ctrl1 port", ctrl1_q, m1);
      check("R8 ctrl2 port", ctrl2_q, m2);
      check("R9 ctrl3 port", ctrl3_q, m3);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic a;
      logic [7:0] v;
      int irq0;
      tick(4); rst_n = 1'b1; tick(4);

      // Reset state: R5, R6, R7, R8, R9
      check_ports();
      check("R13 sda released at reset", {7'd0, sda_oe}, 8'h00);
      burst_read(8'h00, 5, "R5 R6 R7 R8 R9 reset readback");

      // R1: foreign address gets no ack, no register change
      bus_start();
      wbyte(8'h5A, a); check("R1 foreign address nack", {7'd0, a}, 8'h01);
      wbyte(8'h01, a); check("R1 no ack after foreign address", {7'd0, a}, 8'h01);
      wbyte(8'hFF, a); check("R1 no ack on data", {7'd0, a}, 8'h01);
      bus_stop();
      check_ports();

      // R2 + R4: pointer-only write then read from stored pointer
      set_ptr(8'h03, 1'b1);
      check_ports();
      bus_start();
      wbyte(8'h59, a);
      rbyte(1'b0, v); check("R2 R4 read from stored pointer", v, model_rd(3));
      rbyte(1'b1, v); check("R4 pointer increments on read", v, model_rd(4));
      tick(Q);
      check("R4 released after nack", {7'd0, sda_oe}, 8'h00);
      bus_stop();

      // R3 R5 R7 R8 R9 R10: burst write/read sweep with several patterns
      for (int p = 0; p < 6; p++) begin
         logic [7:0] seed;
         seed = 8'(p * 8'h3B) ^ ((p % 2 == 1) ? 8'hFF : 8'h00);
         det_type = 3'(p); vb_comp = p[0]; dcd_timeout = ~p[1]; det_running = p[2];
         burst_write(8'h00, seed, 7);
         check_ports();
         burst_read(8'h00, 7, "R3 R5 R7 R10 burst sweep");
      end

      // R10: write beyond map then read
      burst_write(8'h05, 8'hA5, 3);
      burst_read(8'h05, 3, "R10 beyond map reads zero");
      check_ports();

      // R7 R12: status code sweep, one strobe per status fetch
      for (int c = 0; c < 64; c += 2) begin
         logic [5:0] s;
         s = 6'(c) | 6'(^c[5:1]);
         {det_type, vb_comp, dcd_timeout, det_running} = s[4:0];
         irq0 = irq_cnt;
         burst_read(8'h02, 1, "R7 status layout sweep");
         check("R12 one strobe per status read", 8'(irq_cnt - irq0), 8'd1);
      end
      irq0 = irq_cnt;
      burst_read(8'h03, 2, "R12 no strobe when status not read");
      check("R12 no strobe when status not read", 8'(irq_cnt - irq0), 8'd0);

      // R11: self-clear while a write of 0xFF to ctrl1 commits
      manual_clr = 1'b1;
      burst_write(8'h01, 8'hFF, 1);
      manual_clr = 1'b0;
      m1 = 8'hFD;
      burst_read(8'h01, 1, "R11 clear beats simultaneous write");
      check("R11 ctrl1 port after collision", ctrl1_q, 8'hFD);
      burst_write(8'h01, 8'h02, 1);
      check("R11 bit set by host", ctrl1_q, 8'h02);
      manual_clr = 1'b1; tick(1); manual_clr = 1'b0; tick(1);
      check("R11 self-clear drops bit", ctrl1_q, 8'h00);

      check("R13 sda changed only while scl low", 8'(r13_bad), 8'd0);

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule